// File: doc/BRIEF.md
# Programmable Loop Divider and Phase-Frequency Detector

This block is the digital heart of a synthesizer loop. It takes sampled edge strobes from two oscillator paths (a low-band path and a high-band path). A band-select input picks one of the two paths. The block counts the edges of the chosen path with a programmable down-counter that fires once every N+1 edges, where N is the 13-bit divide code. Each firing of the divider is compared with a reference strobe. A three-state phase-frequency detector turns the comparison into pump-raise and pump-lower commands for an external charge pump.

A reference event that arrives before the divider event means the oscillator is running slow, so the detector raises `pump_up` until the divider catches up. A divider event that arrives first raises `pump_down` until the reference arrives. If both events land in the same cycle, neither command is asserted. A low on the pump enable releases the pump to high impedance for automatic frequency control. While the enable is low, both commands are held low and the detector is held in its idle state.

Detector states are `PD_IDLE`, `PD_UP` and `PD_DOWN`. Its transitions are:
- Ref-lead: `PD_IDLE` to `PD_UP`, on a reference event alone.
- Div-lead: `PD_IDLE` to `PD_DOWN`, on a divider event alone.
- Catch-up: `PD_UP` to `PD_IDLE` on a divider event, and `PD_DOWN` to `PD_IDLE` on a reference event.
- Coincide: stay in `PD_IDLE` when both events occur together.
- Release: any state to `PD_IDLE` while the enable is low.

Top module: `loop_div_pfd`

## Requirements
- R1: After reset, `pump_up` and `pump_down` are 0 and the detector is idle. The divide counter starts at its terminal value, so the first selected oscillator edge after reset produces a divider event.
- R2: With a fixed code N, a divider event occurs on every (N+1)-th selected oscillator edge.
- R3: When `band_fm` is 1, only `fm_edge` is counted. When `band_fm` is 0, only `am_edge` is counted.
- R4: A reference strobe with no pending divider event drives `pump_up` high. `pump_up` stays high until a divider event clears it.
- R5: A divider event with no pending reference drives `pump_down` high. `pump_down` stays high until a reference strobe clears it.
- R6: `pump_up` and `pump_down` are never high in the same cycle.
- R7: While `pump_en` is 0, `pump_hiz` is 1 and both pump commands are 0 in that same cycle. After the edge that samples the low enable, the detector is idle, so re-enabling produces no pump command without a fresh event.
- R8: When the reference strobe and the divider event coincide, no pump command is asserted. When they are one cycle apart, the command lasts exactly one cycle.
- R9: A new value on `div_code` takes effect only when the counter reaches terminal count. A count already in progress completes with the old code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| am_edge | input | 1 | One-cycle strobe per low-band oscillator edge |
| fm_edge | input | 1 | One-cycle strobe per high-band oscillator edge |
| band_fm | input | 1 | 1 selects the high-band path, 0 selects the low-band path |
| div_code | input | 13 | Divide code N; the ratio is N+1 |
| ref_strobe | input | 1 | One-cycle strobe per reference period |
| pump_en | input | 1 | Pump enable; 0 releases the pump to high impedance |
| pump_up | output | 1 | Raise the oscillator frequency (source current) |
| pump_down | output | 1 | Lower the oscillator frequency (sink current) |
| pump_hiz | output | 1 | Pump output released to high impedance |

## Verification
Each strobe sampled at clock edge k is registered once: the oscillator strobe inside the divider and the reference strobe in the top. The detector state then changes at edge k+1. Both pump commands therefore move on the edge after the one that sampled their cause, and `pump_hiz` and the forced-low commands follow `pump_en` in the same cycle. The driver records the cycle in which it applies each stimulus. It queues each expectation stamped with that cycle plus the latency above. The monitor compares outputs at the falling edge only when the stamp matches, and reports a stamp it has passed without matching as a failure.

// File: rtl/lpd_pkg.sv
`timescale 1ns/1ps
package lpd_pkg;
    localparam int LPD_CODE_W = 13;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DOWN = 2'd2
    } pd_state_t;
endpackage

// File: rtl/lpd_divider.sv
`timescale 1ns/1ps
// Programmable down-counter: one tc pulse per (code + 1) input edges.
module lpd_divider #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_in,
    input  logic [W-1:0] code,
    output logic         tc
);
    localparam logic [W-1:0] TERMINAL = '0;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= TERMINAL;
            tc    <= 1'b0;
        end else begin
            tc <= 1'b0;
            if (edge_in) begin
                if (cnt_q == TERMINAL) begin
                    cnt_q <= code;          // new code accepted only here
                    tc    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lpd_pfd.sv
`timescale 1ns/1ps
// Three-state phase-frequency detector.
module lpd_pfd
    import lpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_ev,
    input  logic div_ev,
    output logic up,
    output logic dn
);
    pd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = PD_IDLE;
        end else begin
            unique case (state_q)
                PD_IDLE: begin
                    if (ref_ev && !div_ev)      state_d = PD_UP;
                    else if (div_ev && !ref_ev) state_d = PD_DOWN;
                    else                        state_d = PD_IDLE;
                end
                PD_UP:   if (div_ev) state_d = PD_IDLE;
                PD_DOWN: if (ref_ev) state_d = PD_IDLE;
                default: state_d = PD_IDLE;
            endcase
        end
    end

    always_comb begin
        up = enable && (state_q == PD_UP);
        dn = enable && (state_q == PD_DOWN);
    end
endmodule

// File: rtl/loop_div_pfd.sv
`timescale 1ns/1ps
module loop_div_pfd
    import lpd_pkg::*;
#(
    parameter int DIV_W = LPD_CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             am_edge,
    input  logic             fm_edge,
    input  logic             band_fm,
    input  logic [DIV_W-1:0] div_code,
    input  logic             ref_strobe,
    input  logic             pump_en,
    output logic             pump_up,
    output logic             pump_down,
    output logic             pump_hiz
);
    logic osc_sel;
    logic div_tc;
    logic ref_q;

    assign osc_sel = band_fm ? fm_edge : am_edge;

    // Reference takes one register so both detector inputs have equal latency.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_strobe;
    end

    lpd_divider #(.W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_in (osc_sel),
        .code    (div_code),
        .tc      (div_tc)
    );

    lpd_pfd u_pfd (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (pump_en),
        .ref_ev (ref_q),
        .div_ev (div_tc),
        .up     (pump_up),
        .dn     (pump_down)
    );

    assign pump_hiz = !pump_en;
endmodule

// File: rtl/loop_div_pfd_chk.sv
`timescale 1ns/1ps
module loop_div_pfd_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_sel,
    input logic div_tc,
    input logic ref_q,
    input logic pump_en,
    input logic pump_up,
    input logic pump_down
);
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_down)); // R6

    AST_HIZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_en |=> (!pump_up && !pump_down)); // R7

    AST_TC_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_tc |-> $past(osc_sel)); // R2

    AST_UP_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_up) |-> $past(ref_q)); // R4

    AST_DN_FROM_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_down) |-> $past(div_tc)); // R5

    AST_COINCIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q && div_tc && pump_en && !pump_up && !pump_down)
        |=> (!pump_up && !pump_down)); // R8
endmodule

bind loop_div_pfd loop_div_pfd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_sel   (osc_sel),
    .div_tc    (div_tc),
    .ref_q     (ref_q),
    .pump_en   (pump_en),
    .pump_up   (pump_up),
    .pump_down (pump_down)
);

// File: tb/loop_div_pfd_tb.sv
`timescale 1ns/1ps
module loop_div_pfd_tb;
    typedef struct {
        int    c;
        bit    up;
        bit    dn;
        bit    hiz;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        am_edge = 1'b0, fm_edge = 1'b0, band_fm = 1'b0;
    logic [12:0] div_code = 13'd2;
    logic        ref_strobe = 1'b0, pump_en = 1'b1;
    logic        pump_up, pump_down, pump_hiz;

    int   cyc = 0, now = 0, c = 0;
    int   total = 0, bad = 0;
    bit   done = 1'b0;
    exp_t q[$];
    exp_t it;

    always #2.5 clk = ~clk;

    loop_div_pfd u_dut (
        .clk(clk), .rst_n(rst_n), .am_edge(am_edge), .fm_edge(fm_edge),
        .band_fm(band_fm), .div_code(div_code), .ref_strobe(ref_strobe),
        .pump_en(pump_en), .pump_up(pump_up), .pump_down(pump_down),
        .pump_hiz(pump_hiz)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic step(input bit a, input bit f, input bit r, input bit en = 1'b1);
        @(negedge clk);
        #1;
        am_edge = a; fm_edge = f; ref_strobe = r; pump_en = en;
        now = cyc;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic expect_at(input int cc, input bit u, input bit d, input bit h, input string tag);
        exp_t e;
        int   pos;
        e.c = cc; e.up = u; e.dn = d; e.hiz = h; e.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].c > cc) begin pos = i; break; end
        end
        q.insert(pos, e);
    endtask

    // Monitor: pops expectations whose stamp equals the current cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            total++;                                    // R6 per-cycle exclusivity
            if (pump_up && pump_down) begin
                bad++;
                $display("FAIL R6 cyc=%0d up=%0b dn=%0b expected not both", cyc, pump_up, pump_down);
            end
            while (q.size() > 0 && q[0].c <= cyc) begin
                it = q.pop_front();
                total++;
                if (it.c != cyc || pump_up !== it.up || pump_down !== it.dn || pump_hiz !== it.hiz) begin
                    bad++;
                    $display("FAIL %s cyc=%0d (due %0d) actual up/dn/hiz=%0b%0b%0b expected %0b%0b%0b",
                             it.tag, cyc, it.c, pump_up, pump_down, pump_hiz, it.up, it.dn, it.hiz);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        total++;                                        // R1 during reset
        if (pump_up !== 1'b0 || pump_down !== 1'b0) begin
            bad++;
            $display("FAIL R1 in reset actual up/dn=%0b%0b expected 00", pump_up, pump_down);
        end
        @(negedge clk); #1; rst_n = 1'b1;

        // R1: idle after reset
        step(0, 0, 0); expect_at(now + 1, 0, 0, 0, "R1 idle after reset");

        // R1/R5: first low-band edge hits terminal count
        step(1, 0, 0); c = now;
        expect_at(c + 1, 0, 0, 0, "R5 not yet");
        expect_at(c + 2, 0, 1, 0, "R1 first edge gives divider event");
        idle(2); expect_at(now + 1, 0, 1, 0, "R5 down held");
        step(0, 0, 1); c = now;
        expect_at(c + 1, 0, 1, 0, "R5 held until ref");
        expect_at(c + 2, 0, 0, 0, "R5 cleared by ref");
        idle(2);

        // R2: N=2 divides by 3
        step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); c = now;
        expect_at(c + 2, 0, 0, 0, "R2 no event after 2 edges");
        step(0, 0, 0); step(1, 0, 0); c = now;
        expect_at(c + 1, 0, 0, 0, "R2 latency");
        expect_at(c + 2, 0, 1, 0, "R2 event on third edge");
        step(0, 0, 0); step(0, 0, 1); idle(3);

        // R4: reference leads
        step(0, 0, 1); c = now;
        expect_at(c + 1, 0, 0, 0, "R4 latency");
        expect_at(c + 2, 1, 0, 0, "R4 up after ref");
        step(0, 0, 0); step(1, 0, 0); step(1, 0, 0);
        expect_at(now + 2, 1, 0, 0, "R4 up held");
        step(1, 0, 0); c = now;
        expect_at(c + 1, 1, 0, 0, "R4 up held to divider event");
        expect_at(c + 2, 0, 0, 0, "R4 cleared by divider event");
        idle(3);

        // R3: high band selected, low-band edges ignored
        band_fm = 1'b1;
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        expect_at(now + 2, 0, 0, 0, "R3 am edges ignored in fm band");
        idle(2);
        expect_at(now + 1, 0, 0, 0, "R3 still idle");
        step(0, 1, 0); step(0, 1, 0); step(0, 1, 0); c = now;
        expect_at(c + 2, 0, 1, 0, "R3 fm edges counted");
        step(0, 0, 0); step(0, 0, 1); idle(3);

        // R8: coincident events
        step(0, 1, 0); step(0, 1, 0); step(0, 1, 1); c = now;
        expect_at(c + 1, 0, 0, 0, "R8 coincident quiet 1");
        expect_at(c + 2, 0, 0, 0, "R8 coincident quiet 2");
        expect_at(c + 3, 0, 0, 0, "R8 coincident quiet 3");
        idle(3);

        // R8: one-cycle offset gives one-cycle pulse
        step(0, 1, 0); step(0, 1, 0); step(0, 0, 1); c = now;
        step(0, 1, 0);
        expect_at(c + 2, 1, 0, 0, "R8 one-cycle up");
        expect_at(c + 3, 0, 0, 0, "R8 up lasts one cycle");
        idle(3);

        // R9: code change mid-count
        step(0, 1, 0);
        div_code = 13'd5;
        step(0, 1, 0); step(0, 1, 0); c = now;
        expect_at(c + 2, 0, 1, 0, "R9 old code completes");
        step(0, 0, 0); step(0, 0, 1); idle(2);
        for (int i = 0; i < 5; i++) step(0, 1, 0);
        expect_at(now + 2, 0, 0, 0, "R9 new code no event after 5");
        step(0, 1, 0); c = now;
        expect_at(c + 2, 0, 1, 0, "R9 new code event on 6th edge");
        step(0, 0, 0); step(0, 0, 1); idle(3);

        // R7: high impedance forces pump off and resets detector
        step(0, 0, 1); expect_at(now + 2, 1, 0, 0, "R7 up before release");
        idle(2);
        step(0, 0, 0, 0); c = now;
        expect_at(c + 1, 0, 0, 1, "R7 release forces pump off");
        step(0, 0, 1, 0); expect_at(now + 1, 0, 0, 1, "R7 ref while released");
        step(0, 0, 0, 0);
        step(0, 0, 0, 1); c = now;
        expect_at(c + 1, 0, 0, 0, "R7 detector was reset");
        expect_at(c + 2, 0, 0, 0, "R7 no command after re-enable");
        idle(4);

        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL all pending expectations actual %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule